// File: doc/BRIEF.md
# Multi-Bank Pin Interrupt Detector

This block watches the interrupt-capable input lines of several GPIO banks and merges what it sees into a single interrupt request. Each line has its own 4-bit trigger code. The code selects one of five detectors: rising edge, falling edge, either edge, high level or low level. The inputs pass through a two-stage synchroniser before detection. A detected event latches a per-pin pending flag, and that flag stays set until software clears it.

Software programs the block through a plain 32-bit register port. The port has a write strobe, a word address and a combinational read-data bus. Each bank has its own register window. The window holds four trigger-configuration words, an enable mask, a pending mask and a debounce word. The block keeps the debounce word only as read/write storage. The interrupt output is raised whenever any pin in any bank is both pending and enabled.

Top module: `gpio_bank_irq`

## Requirements
- R1: Bank N's register window starts at byte address 0x200 + 0x20*N. Window offsets are: 0x00, 0x04, 0x08 and 0x0C for trigger configuration; 0x10 for enable (bit p = pin p); 0x14 for pending; 0x18 for debounce. Addresses must be word-aligned.
- R2: Pin p's trigger code is the 4-bit field at bit 4*(p mod 8) of the configuration word at window offset 4*(p/8).
- R3: Code 0 latches pending on a rising edge, code 1 on a falling edge and code 4 on either edge. An edge is a change of the synchronised sample from one clock to the next.
- R4: Code 2 (high level) and code 3 (low level) latch pending on every cycle that the level is present. A pending bit cleared while the level is still present reappears.
- R5: Codes 5 to 15 never latch a pending bit.
- R6: Writing the pending word clears each bit written as 1 and leaves each bit written as 0 unchanged. A new event in the same cycle wins over the clear.
- R7: Pending bits latch whatever the enable setting. irqOut is high exactly when some bank has a bit that is both pending and enabled. Clearing the enable drops irqOut and leaves the pending bit in place.
- R8: After reset, every configuration, enable, pending and debounce word reads zero, and irqOut is low.
- R9: A read of an unmapped or misaligned address returns zero. A write to such an address changes no register.
- R10: The debounce word of each bank reads back the value last written to it and has no effect on detection.
- R11: Suppose a pin changes before clock edge k. Its pending bit is still clear after edge k+1 and is set after edge k+2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | ADDR_W | Byte address of the register access |
| regWrData | input | DATA_W | Write data |
| regRdData | output | DATA_W | Combinational read data for regAddr |
| pinIn | input | NUM_BANKS*PINS | Interrupt lines; bank b occupies bits b*PINS and up |
| irqOut | output | 1 | Combined interrupt request |

## Verification
The bound checker watches several properties on every cycle. Pending bits only drop in the cycle after a pending-word write. The enable mask only changes after an enable write. Unmapped addresses always read zero. irqOut stays low while no enable is set, and it is never high unless something is pending. Other behaviour can only be shown by the bench's scenarios. This covers each trigger code's response to chosen pin waveforms, the exact two-edge detection latency, and level triggers reappearing after a clear. It also covers the field placement of each pin's code and debounce-word storage.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  localparam int BANK_W = 4;

  typedef enum logic [3:0] {
    TRIG_RISE = 4'd0,
    TRIG_FALL = 4'd1,
    TRIG_HIGH = 4'd2,
    TRIG_LOW  = 4'd3,
    TRIG_BOTH = 4'd4
  } trigMode_e;

  typedef enum logic [2:0] {
    SEL_CFG0 = 3'd0,
    SEL_CFG1 = 3'd1,
    SEL_CFG2 = 3'd2,
    SEL_CFG3 = 3'd3,
    SEL_EN   = 3'd4,
    SEL_STA  = 3'd5,
    SEL_DEB  = 3'd6,
    SEL_NONE = 3'd7
  } regSel_e;

  typedef struct packed {
    logic              hit;
    logic              wr;
    logic [BANK_W-1:0] bank;
    regSel_e           sel;
  } regStrobe_t;
endpackage

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl
  import gpio_irq_pkg::*;
#(
  parameter int NUM_BANKS = 3,
  parameter int ADDR_W    = 12
) (
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWrEn,
  output regStrobe_t        stb
);
  localparam logic [ADDR_W-1:0] WIN_BASE = ADDR_W'('h200);
  localparam logic [ADDR_W-1:0] BANK_LIM = ADDR_W'(NUM_BANKS);

  logic [ADDR_W-1:0] offset;
  logic inRange, bankOk, wordOk, hit;

  always_comb begin
    offset  = regAddr - WIN_BASE;
    inRange = regAddr >= WIN_BASE;
    bankOk  = (offset >> 5) < BANK_LIM;
    wordOk  = (offset[1:0] == 2'b00) && (offset[4:2] <= 3'd6);
    hit     = inRange && bankOk && wordOk;
    stb.hit  = hit;
    stb.wr   = hit && regWrEn;
    stb.bank = offset[5 +: BANK_W];
    stb.sel  = hit ? regSel_e'(offset[4:2]) : SEL_NONE;
  end
endmodule

// File: rtl/gpio_irq_dp.sv
module gpio_irq_dp
  import gpio_irq_pkg::*;
#(
  parameter int NUM_BANKS = 3,
  parameter int PINS      = 32,
  parameter int DATA_W    = 32
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  regStrobe_t                stb,
  input  logic [DATA_W-1:0]         wrData,
  input  logic [NUM_BANKS*PINS-1:0] pinIn,
  output logic [DATA_W-1:0]         rdData,
  output logic [NUM_BANKS*PINS-1:0] enFlat,
  output logic [NUM_BANKS*PINS-1:0] staFlat
);
  localparam int FIELD_W  = 4;
  localparam int PER_WORD = DATA_W / FIELD_W;
  localparam int CFG_REGS = (PINS + PER_WORD - 1) / PER_WORD;

  logic [DATA_W-1:0] bankRd [NUM_BANKS];

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic [CFG_REGS-1:0][DATA_W-1:0] cfgR;
    logic [PINS-1:0] enR, staR, syncA, syncB, prevR, pinEvt, clrMask;
    logic [DATA_W-1:0] debR;
    logic selBank;

    assign selBank = stb.wr && (stb.bank == BANK_W'(b));
    assign clrMask = (selBank && stb.sel == SEL_STA) ? wrData[PINS-1:0] : '0;

    for (genvar p = 0; p < PINS; p++) begin : g_pin
      trigMode_e mode;
      logic rise, fall;
      assign mode = trigMode_e'(cfgR[p / PER_WORD][FIELD_W * (p % PER_WORD) +: FIELD_W]);
      assign rise = syncB[p] & ~prevR[p];
      assign fall = ~syncB[p] & prevR[p];
      assign pinEvt[p] = ((mode == TRIG_RISE) & rise)
                       | ((mode == TRIG_FALL) & fall)
                       | ((mode == TRIG_BOTH) & (rise | fall))
                       | ((mode == TRIG_HIGH) & syncB[p])
                       | ((mode == TRIG_LOW)  & ~syncB[p]);
    end

    always_ff @(posedge clk) begin
      if (!rstN) begin
        cfgR  <= '0;
        enR   <= '0;
        staR  <= '0;
        debR  <= '0;
        syncA <= '0;
        syncB <= '0;
        prevR <= '0;
      end else begin
        syncA <= pinIn[b*PINS +: PINS];
        syncB <= syncA;
        prevR <= syncB;
        staR  <= (staR & ~clrMask) | pinEvt;
        if (selBank) begin
          if (stb.sel == SEL_EN)  enR  <= wrData[PINS-1:0];
          if (stb.sel == SEL_DEB) debR <= wrData;
          for (int r = 0; r < CFG_REGS; r++) begin
            if (stb.sel == regSel_e'(r)) cfgR[r] <= wrData;
          end
        end
      end
    end

    always_comb begin
      bankRd[b] = '0;
      case (stb.sel)
        SEL_EN:  bankRd[b] = DATA_W'(enR);
        SEL_STA: bankRd[b] = DATA_W'(staR);
        SEL_DEB: bankRd[b] = debR;
        default: begin
          for (int r = 0; r < CFG_REGS; r++) begin
            if (stb.sel == regSel_e'(r)) bankRd[b] = cfgR[r];
          end
        end
      endcase
    end

    assign enFlat[b*PINS +: PINS]  = enR;
    assign staFlat[b*PINS +: PINS] = staR;
  end

  always_comb begin
    rdData = '0;
    if (stb.hit) begin
      for (int b = 0; b < NUM_BANKS; b++) begin
        if (stb.bank == BANK_W'(b)) rdData = bankRd[b];
      end
    end
  end
endmodule

// File: rtl/gpio_bank_irq.sv
module gpio_bank_irq
  import gpio_irq_pkg::*;
#(
  parameter int NUM_BANKS = 3,
  parameter int PINS      = 32,
  parameter int ADDR_W    = 12,
  parameter int DATA_W    = 32
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      regWrEn,
  input  logic [ADDR_W-1:0]         regAddr,
  input  logic [DATA_W-1:0]         regWrData,
  output logic [DATA_W-1:0]         regRdData,
  input  logic [NUM_BANKS*PINS-1:0] pinIn,
  output logic                      irqOut
);
  regStrobe_t stb;
  logic [NUM_BANKS*PINS-1:0] enFlat, staFlat;

  gpio_irq_ctrl #(.NUM_BANKS(NUM_BANKS), .ADDR_W(ADDR_W)) u_ctrl (
    .regAddr(regAddr), .regWrEn(regWrEn), .stb(stb)
  );

  gpio_irq_dp #(.NUM_BANKS(NUM_BANKS), .PINS(PINS), .DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .wrData(regWrData), .pinIn(pinIn),
    .rdData(regRdData), .enFlat(enFlat), .staFlat(staFlat)
  );

  assign irqOut = |(enFlat & staFlat);
endmodule

// File: rtl/gpio_bank_irq_chk.sv
module gpio_bank_irq_chk
  import gpio_irq_pkg::*;
#(
  parameter int NUM_BANKS = 3,
  parameter int PINS      = 32,
  parameter int DATA_W    = 32
) (
  input logic                      clk,
  input logic                      rstN,
  input regStrobe_t                stb,
  input logic [NUM_BANKS*PINS-1:0] enFlat,
  input logic [NUM_BANKS*PINS-1:0] staFlat,
  input logic [DATA_W-1:0]         rdData,
  input logic                      irq
);
  // R6: a pending bit only drops right after a pending-word write
  p_pend_sticky_r6: assert property (@(posedge clk) disable iff (!rstN)
    (|($past(staFlat) & ~staFlat)) |-> $past(stb.wr && stb.sel == SEL_STA));

  // R9: enable mask moves only after a mapped enable write
  p_en_write_only_r9: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(enFlat) |-> $past(stb.wr && stb.sel == SEL_EN));

  // R9: unmapped addresses read zero
  p_unmapped_zero_r9: assert property (@(posedge clk) disable iff (!rstN)
    !stb.hit |-> (rdData == '0));

  // R7: nothing enabled means no request
  p_quiet_no_en_r7: assert property (@(posedge clk) disable iff (!rstN)
    (enFlat == '0) |-> !irq);

  // R7: a request always has a pending source
  p_irq_has_src_r7: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> (|staFlat));
endmodule

bind gpio_bank_irq gpio_bank_irq_chk #(
  .NUM_BANKS(NUM_BANKS), .PINS(PINS), .DATA_W(DATA_W)
) u_chk (
  .clk(clk), .rstN(rstN), .stb(stb), .enFlat(enFlat), .staFlat(staFlat),
  .rdData(regRdData), .irq(irqOut)
);

// File: tb/tb_gpio_bank_irq.sv
module tb_gpio_bank_irq;
  localparam int NB = 3;
  localparam int NP = 32;

  logic clk = 0;
  logic rstN = 0;
  logic regWrEn = 0;
  logic [11:0] regAddr = '0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic [NB*NP-1:0] pins = '0;
  logic irqOut;

  int checks = 0;
  int errors = 0;
  logic [3:0]  cfgM [NB][NP];
  logic [31:0] enM [NB];
  logic [31:0] expSta [NB];

  gpio_bank_irq dut (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .pinIn(pins), .irqOut(irqOut)
  );

  always #2 clk = ~clk;

  function automatic logic [11:0] ra(int bank, int off);
    return 12'(32'h200 + 32'h20 * bank + off);
  endfunction

  function automatic logic evtOf(logic [3:0] m, logic o, logic n);
    case (m)
      4'd0: return !o && n;
      4'd1: return o && !n;
      4'd4: return o != n;
      4'd2: return n;
      4'd3: return !n;
      default: return 1'b0;
    endcase
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [11:0] a, logic [31:0] d);
    @(negedge clk);
    regAddr = a; regWrData = d; regWrEn = 1;
    @(negedge clk);
    regWrEn = 0;
  endtask

  task automatic rd(logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    regAddr = a;
    #1 d = regRdData;
  endtask

  task automatic waitCyc(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(200000 * 4);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] v;
    void'($urandom(32'd20240611));
    repeat (5) @(negedge clk);
    rstN = 1;

    // R8 reset state
    rd(ra(0, 0), v);    check("R8 cfg0", v, 0);
    rd(ra(1, 16), v);   check("R8 enable", v, 0);
    rd(ra(2, 20), v);   check("R8 pending", v, 0);
    rd(ra(0, 24), v);   check("R8 debounce", v, 0);
    check("R8 irq", 32'(irqOut), 0);

    // R11 latency, R3 rising via default code 0 on bank0 pin3
    @(negedge clk);
    regAddr = ra(0, 20);
    pins[3] = 1;
    @(posedge clk); @(posedge clk); #1;
    check("R11 not yet after k+1", regRdData & 32'h8, 0);
    @(posedge clk); #1;
    check("R11 set after k+2", regRdData & 32'h8, 32'h8);

    // R7 enable gating
    @(negedge clk); #1;
    check("R7 pending but disabled", 32'(irqOut), 0);
    wr(ra(0, 16), 32'h8);
    check("R7 enabled irq", 32'(irqOut), 1);
    wr(ra(0, 16), 32'h0);
    check("R7 disable drops irq", 32'(irqOut), 0);
    rd(ra(0, 20), v);   check("R7 pending kept", v, 32'h8);

    // R6 write-0 no effect, write-1 clears
    wr(ra(0, 20), 32'h0);
    rd(ra(0, 20), v);   check("R6 write zero keeps", v, 32'h8);
    wr(ra(0, 20), 32'h8);
    rd(ra(0, 20), v);   check("R6 write one clears", v, 0);

    // R9 unmapped accesses
    wr(ra(0, 28), 32'hFFFF_FFFF);
    wr(12'h010, 32'hFFFF_FFFF);
    wr(ra(NB, 16), 32'hFFFF_FFFF);
    wr(ra(0, 18), 32'hFFFF_FFFF);
    rd(ra(0, 28), v);   check("R9 hole reads zero", v, 0);
    rd(ra(NB, 16), v);  check("R9 beyond banks zero", v, 0);
    rd(ra(0, 18), v);   check("R9 misaligned zero", v, 0);
    rd(ra(0, 16), v);   check("R9 enable untouched", v, 0);
    rd(ra(0, 24), v);   check("R9 debounce untouched", v, 0);

    // R10 debounce storage, R1 bank1 window, detection unaffected
    wr(ra(1, 24), 32'hA5A5_0F0F);
    rd(ra(1, 24), v);   check("R10 debounce readback", v, 32'hA5A5_0F0F);
    rd(ra(2, 24), v);   check("R1 other bank debounce", v, 0);
    @(negedge clk); pins[NP + 0] = 1;
    waitCyc(4);
    rd(ra(1, 20), v);   check("R10 R1 bank1 detect", v, 32'h1);

    // R4 level modes: pin9 high (cfg1 field1), pin10 low (cfg1 field2)
    wr(ra(0, 4), (32'd2 << 4) | (32'd3 << 8));
    waitCyc(3);
    rd(ra(0, 20), v);   check("R4 low level sets", v & 32'h400, 32'h400);
    @(negedge clk); pins[9] = 1;
    waitCyc(4);
    wr(ra(0, 20), 32'h600);
    waitCyc(2);
    rd(ra(0, 20), v);   check("R4 level reappears", v & 32'h600, 32'h600);
    @(negedge clk); pins[9] = 0; pins[10] = 1;
    waitCyc(4);
    wr(ra(0, 20), 32'h600);
    waitCyc(3);
    rd(ra(0, 20), v);   check("R4 inactive level stays clear", v & 32'h600, 0);

    // R5 invalid code on pin0
    wr(ra(0, 0), 32'h7);
    @(negedge clk); pins[0] = 1;
    waitCyc(4);
    @(negedge clk); pins[0] = 0;
    waitCyc(4);
    rd(ra(0, 20), v);   check("R5 code 7 silent", v & 32'h1, 0);

    // R3/R2: pin17 falling (cfg2 field1), pin20 both (cfg2 field4)
    wr(ra(0, 8), (32'd1 << 4) | (32'd4 << 16));
    wr(ra(0, 20), 32'hFFFF_FFFF);
    @(negedge clk); pins[17] = 1; pins[20] = 1;
    waitCyc(4);
    rd(ra(0, 20), v);
    check("R3 falling ignores rise", v & 32'h20000, 0);
    check("R3 both sees rise", v & 32'h100000, 32'h100000);
    wr(ra(0, 20), 32'h120000);
    @(negedge clk); pins[17] = 0; pins[20] = 0;
    waitCyc(4);
    rd(ra(0, 20), v);
    check("R3 R2 falling seen", v & 32'h20000, 32'h20000);
    check("R3 both sees fall", v & 32'h100000, 32'h100000);

    // R7 OR across banks: bank2 pin5
    wr(ra(2, 16), 32'h20);
    @(negedge clk); pins[2*NP + 5] = 1;
    waitCyc(4);
    check("R7 bank2 raises irq", 32'(irqOut), 1);
    wr(ra(2, 20), 32'h20);
    check("R7 cleared bank2 irq low", 32'(irqOut), 0);

    // Random: R2 R3 R4 R5 R7 against bench model
    for (int it = 0; it < 60; it++) begin
      for (int b = 0; b < NB; b++) begin
        for (int p = 0; p < NP; p++) begin
          int m;
          m = $urandom % 8;
          if (m == 6) m = 15;
          cfgM[b][p] = 4'(m);
        end
        for (int r = 0; r < 4; r++) begin
          logic [31:0] w;
          w = '0;
          for (int f = 0; f < 8; f++) w[4*f +: 4] = cfgM[b][8*r + f];
          wr(ra(b, 4*r), w);
        end
        enM[b] = $urandom;
        wr(ra(b, 16), enM[b]);
      end
      waitCyc(1);
      for (int b = 0; b < NB; b++) wr(ra(b, 20), 32'hFFFF_FFFF);
      waitCyc(3);
      for (int b = 0; b < NB; b++) begin
        expSta[b] = '0;
        for (int p = 0; p < NP; p++)
          expSta[b][p] = (cfgM[b][p] == 4'd2) ? pins[b*NP+p]
                       : (cfgM[b][p] == 4'd3) ? !pins[b*NP+p] : 1'b0;
      end
      @(negedge clk);
      begin
        logic [NB*NP-1:0] oldPins;
        oldPins = pins;
        for (int b = 0; b < NB; b++) pins[b*NP +: NP] = pins[b*NP +: NP] ^ ($urandom & $urandom);
        for (int b = 0; b < NB; b++)
          for (int p = 0; p < NP; p++)
            expSta[b][p] = expSta[b][p] | evtOf(cfgM[b][p], oldPins[b*NP+p], pins[b*NP+p]);
      end
      waitCyc(4);
      begin
        logic expIrq;
        expIrq = 0;
        for (int b = 0; b < NB; b++) begin
          rd(ra(b, 20), v);
          check("R2 R3 R4 R5 random pending", v, expSta[b]);
          expIrq = expIrq | (|(expSta[b] & enM[b]));
        end
        check("R7 random irq", 32'(irqOut), 32'(expIrq));
      end
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule